// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from a transmit FIFO, shifts each one out on the data-out pin most-significant bit first, and shifts the data-in pin into a receive word that it hands to a receive FIFO. The word length can be anywhere from 4 to 32 bits. Each word sits right-justified in a 32-bit FIFO entry. A divider outside the block supplies a one-cycle `tick`. Every serial clock half-period uses one tick, so the serial clock rate is half the tick rate.

A transfer begins with a one-cycle `go` pulse that carries the number of words to move. The engine then runs through the states IDLE, LOAD, SHIFT and FINISH for each word, and visits STALL when a word is owed but the transmit FIFO is empty. The state transitions are:

- IDLE→LOAD when `go` arrives with a non-zero count.
- LOAD→SHIFT when transmit data is present.
- LOAD→STALL when it is absent.
- STALL→LOAD when data appears.
- SHIFT→FINISH on the trailing tick of the last bit.
- FINISH→LOAD while words remain.
- FINISH→IDLE after the final word.

Chip-select lines, output enables and the serial clock idle level come from static control inputs. These inputs must be held steady for the whole transfer.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `busy`, `done`, `tx_pop` and `rx_push` are low, every chip-select line sits at its inactive level, and `spi_sclk` equals `clk_idle_high`.
- R2: `word_len_m1` holds the word length minus one. Bits word_len_m1..0 of each transmit entry are sent most-significant bit first, and higher bits are ignored.
- R3: Each received word appears on `rx_data` right-justified: the first bit received lands at bit word_len_m1 and the upper bits are zero. It is valid for one cycle while `rx_push` is high.
- R4: With `sample_first`=1, data-out is valid before the first clock edge of a bit, data-in is sampled on the leading edge, and data-out changes on the trailing edge. With `sample_first`=0, data-out changes on the leading edge and data-in is sampled on the trailing edge.
- R5: While idle, `spi_sclk` equals `clk_idle_high`. The leading edge of every bit moves the clock away from that level.
- R6: With `loopback`=1, the receive path takes the engine's own data-out and `miso` has no effect on `rx_data`.
- R7: The serial clock changes only in a cycle after `tick` was high. Each bit takes exactly two edges, so a transfer of N words of L bits shows 2·N·L edges.
- R8: `cs_sel` picks one of the chip-select lines. `cs_pol[i]`=1 makes line i active-high and 0 makes it active-low. At most one line is active at any time.
- R9: `cs_force`=1 holds the selected line active whether or not a transfer runs. `cs_auto`=1 makes it active only while `busy` is high. With both bits low, every line stays inactive.
- R10: `cs_oe` equals the inverse of `cs_tristate`. `pin_oe` is high while busy, or at any time when `no_tristate`=1.
- R11: When a word is owed and `tx_valid` is low, the serial clock stops at its idle level and `clk_underrun` pulses for exactly one cycle. Shifting resumes once data arrives.
- R12: If `rx_full` is high when a word completes, that word is dropped: no `rx_push` occurs and `clk_overrun` pulses for one cycle.
- R13: `word_len_m1` values 0 to 2 are treated as 3, which gives 4-bit words.
- R14: `go` loads the word count and raises `busy`. `done` pulses for one cycle after the last word completes and `busy` then falls. A `go` with a zero count starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_len_m1 | input | 5 | Word length minus one |
| sample_first | input | 1 | 1: sample on leading edge; 0: drive on leading edge |
| loopback | input | 1 | Route data-out to the receive path |
| clk_idle_high | input | 1 | Idle level of the serial clock |
| cs_sel | input | 2 | Chip-select line index |
| cs_pol | input | 4 | Per-line active level (1 = high) |
| cs_force | input | 1 | Hold selected line active |
| cs_auto | input | 1 | Activate selected line while busy |
| no_tristate | input | 1 | Drive clock/data pins when idle |
| cs_tristate | input | 1 | Float chip-select lines |
| tick | input | 1 | Half-period enable from the divider |
| go | input | 1 | Start pulse |
| go_words | input | 16 | Words in this transfer |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 32 | Transmit FIFO head entry |
| tx_pop | output | 1 | Consume transmit head entry |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Write `rx_data` to receive FIFO |
| rx_data | output | 32 | Received word, right-justified |
| miso | input | 1 | Serial data in |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 4 | Chip-select lines |
| cs_oe | output | 1 | Chip-select drive enable |
| pin_oe | output | 1 | Clock/data drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last word finished |
| clk_underrun | output | 1 | Stall on empty transmit FIFO |
| clk_overrun | output | 1 | Word dropped on full receive FIFO |

## Verification
The assertions watch four things on every cycle. The serial clock moves only after a tick and rests at its idle level in IDLE. It stays quiet in STALL. At most one chip-select line is active. Data-out holds across its sampling edge in both phase settings. Bit order, right-justification, loopback isolation from `miso`, the length clamp, and the exact edge count are shown only by the scenarios. In those scenarios a slave model captures data-out and feeds patterned data-in. Underrun and overrun counting and the forced or automatic chip-select levels are also shown only by the scenarios.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH,
        ST_STALL
    } eng_state_e;
endpackage

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
    parameter int NUM_CS = 4,
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic [NUM_CS-1:0] cs_pol,
    input  logic              cs_force,
    input  logic              cs_auto,
    input  logic              busy,
    input  logic              no_tristate,
    input  logic              cs_tristate,
    output logic [NUM_CS-1:0] cs_line,
    output logic              cs_oe,
    output logic              pin_oe
);
    logic assert_sel;

    assign assert_sel = cs_force | (cs_auto & busy);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic hit;
        assign hit        = assert_sel && (cs_sel == SEL_W'(i));
        assign cs_line[i] = hit ? cs_pol[i] : ~cs_pol[i];
    end

    assign cs_oe  = ~cs_tristate;
    assign pin_oe = busy | no_tristate;

    AST_ONE_CS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs_line ^ cs_pol))) else $error("more than one CS active"); // R8
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lead,
    input  logic              trail,
    input  logic              sample_first,
    input  logic              loopback,
    input  logic              clk_idle_high,
    input  logic              miso,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [DATA_W-1:0] tx_data,
    output logic              mosi,
    output logic              sclk,
    output logic              sclk_act,
    output logic              bit_zero,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_sh;
    logic [IDX_W-1:0]  bit_idx;
    logic              mosi_r;
    logic              sclk_r;
    logic              din;

    assign din = loopback ? mosi_r : miso;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
            rx_sh   <= '0;
            bit_idx <= '0;
            mosi_r  <= 1'b0;
            sclk_r  <= 1'b0;
        end else if (load) begin
            tx_word <= tx_data;
            rx_sh   <= '0;
            bit_idx <= last_idx;
            sclk_r  <= 1'b0;
            if (sample_first) mosi_r <= tx_data[last_idx];
        end else if (lead) begin
            sclk_r <= 1'b1;
            if (sample_first) rx_sh  <= {rx_sh[DATA_W-2:0], din};
            else              mosi_r <= tx_word[bit_idx];
        end else if (trail) begin
            sclk_r <= 1'b0;
            if (!sample_first) rx_sh <= {rx_sh[DATA_W-2:0], din};
            if (bit_idx != '0) begin
                bit_idx <= bit_idx - IDX_W'(1);
                if (sample_first) mosi_r <= tx_word[bit_idx - IDX_W'(1)];
            end
        end
    end

    assign mosi     = mosi_r;
    assign sclk_act = sclk_r;
    assign sclk     = sclk_r ^ clk_idle_high;
    assign bit_zero = (bit_idx == '0);
    assign rx_word  = rx_sh;

    AST_MOSI_HOLD_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lead && sample_first) |=> $stable(mosi_r)) else $error("mosi moved at sample edge"); // R4
    AST_MOSI_HOLD_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (trail && !sample_first) |=> $stable(mosi_r)) else $error("mosi moved at sample edge"); // R4
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int SEL_W = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  word_len_m1,
    input  logic              sample_first,
    input  logic              loopback,
    input  logic              clk_idle_high,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic [NUM_CS-1:0] cs_pol,
    input  logic              cs_force,
    input  logic              cs_auto,
    input  logic              no_tristate,
    input  logic              cs_tristate,
    input  logic              tick,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_words,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs,
    output logic              cs_oe,
    output logic              pin_oe,
    output logic              busy,
    output logic              done,
    output logic              clk_underrun,
    output logic              clk_overrun
);
    localparam logic [IDX_W-1:0] MIN_IDX = IDX_W'(3);

    eng_state_e       state, state_nx;
    logic [CNT_W-1:0] words_left;
    logic             half;
    logic [IDX_W-1:0] last_idx;
    logic             load, lead, trail, bit_zero, sclk_act, last_word;

    assign last_idx  = (word_len_m1 < MIN_IDX) ? MIN_IDX : word_len_m1;
    assign last_word = (words_left == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (go && go_words != '0) state_nx = ST_LOAD;
            ST_LOAD:   state_nx = tx_valid ? ST_SHIFT : ST_STALL;
            ST_SHIFT:  if (tick && half && bit_zero) state_nx = ST_FINISH;
            ST_FINISH: state_nx = last_word ? ST_IDLE : ST_LOAD;
            ST_STALL:  if (tx_valid) state_nx = ST_LOAD;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // word count and half-period phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_left <= '0;
            half       <= 1'b0;
        end else begin
            if (state == ST_IDLE && go && go_words != '0) words_left <= go_words;
            else if (state == ST_FINISH)                    words_left <= words_left - CNT_W'(1);
            if (state == ST_LOAD)                    half <= 1'b0;
            else if (state == ST_SHIFT && tick)      half <= ~half;
        end
    end

    // outputs
    always_comb begin
        load         = (state == ST_LOAD) && tx_valid;
        tx_pop       = load;
        clk_underrun = (state == ST_LOAD) && !tx_valid;
        lead         = (state == ST_SHIFT) && tick && !half;
        trail        = (state == ST_SHIFT) && tick && half;
        rx_push      = (state == ST_FINISH) && !rx_full;
        clk_overrun  = (state == ST_FINISH) && rx_full;
        done         = (state == ST_FINISH) && last_word;
        busy         = (state != ST_IDLE);
    end

    spi_shift_path #(.DATA_W(DATA_W)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .lead         (lead),
        .trail        (trail),
        .sample_first (sample_first),
        .loopback     (loopback),
        .clk_idle_high(clk_idle_high),
        .miso         (miso),
        .last_idx     (last_idx),
        .tx_data      (tx_data),
        .mosi         (spi_mosi),
        .sclk         (spi_sclk),
        .sclk_act     (sclk_act),
        .bit_zero     (bit_zero),
        .rx_word      (rx_data)
    );

    spi_cs_ctrl #(.NUM_CS(NUM_CS)) u_cs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_sel     (cs_sel),
        .cs_pol     (cs_pol),
        .cs_force   (cs_force),
        .cs_auto    (cs_auto),
        .busy       (busy),
        .no_tristate(no_tristate),
        .cs_tristate(cs_tristate),
        .cs_line    (spi_cs),
        .cs_oe      (cs_oe),
        .pin_oe     (pin_oe)
    );

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_act != $past(sclk_act)) |-> $past(tick)) else $error("sclk edge without tick"); // R7
    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (spi_sclk == clk_idle_high)) else $error("sclk not idle"); // R5
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> !sclk_act) else $error("sclk active in stall"); // R11
endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
    localparam int DW = 32;
    localparam int NCS = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] word_len_m1 = 5'd7;
    logic sample_first = 1'b1, loopback = 1'b0, clk_idle_high = 1'b0;
    logic [1:0] cs_sel = 2'd0;
    logic [NCS-1:0] cs_pol = '0;
    logic cs_force = 1'b0, cs_auto = 1'b0, no_tristate = 1'b0, cs_tristate = 1'b0;
    logic tick;
    logic go = 1'b0;
    logic [CW-1:0] go_words = '0;
    logic tx_valid;
    logic [DW-1:0] tx_data;
    logic tx_pop, rx_full = 1'b0, rx_push;
    logic [DW-1:0] rx_data;
    logic miso_r = 1'b0;
    logic spi_sclk, spi_mosi;
    logic [NCS-1:0] spi_cs;
    logic cs_oe, pin_oe, busy, done, clk_underrun, clk_overrun;

    int checks = 0, fails = 0, cyc = 0;
    int cfg_len = 8;
    logic [31:0] tx_mem [0:15];
    int tx_rd = 0, tx_avail = 0;
    logic [31:0] cap [0:15];
    logic [31:0] rx_log [0:15];
    int rx_n = 0, ur_n = 0, or_n = 0, done_n = 0, edges = 0, slv_cnt = 0;
    bit mon_en = 1'b0;
    logic prev_sclk = 1'b0;

    always #2 clk = ~clk;

    spi_shift_engine i_spi_shift_engine (
        .clk(clk), .rst_n(rst_n), .word_len_m1(word_len_m1), .sample_first(sample_first),
        .loopback(loopback), .clk_idle_high(clk_idle_high), .cs_sel(cs_sel), .cs_pol(cs_pol),
        .cs_force(cs_force), .cs_auto(cs_auto), .no_tristate(no_tristate),
        .cs_tristate(cs_tristate), .tick(tick), .go(go), .go_words(go_words),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_data(rx_data), .miso(miso_r), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs(spi_cs), .cs_oe(cs_oe), .pin_oe(pin_oe), .busy(busy),
        .done(done), .clk_underrun(clk_underrun), .clk_overrun(clk_overrun)
    );

    function automatic logic [31:0] msk(int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    endfunction

    function automatic logic [31:0] slv_pat(int i);
        return 32'h6B2D_91E7 ^ (32'(i) * 32'h0F1E_2D3B);
    endfunction

    function automatic logic [31:0] tx_pat(int i, int fld);
        return (32'hC3A5_1E69 + 32'(i) * 32'h2468_ACE1) ^ 32'(fld);
    endfunction

    function automatic logic slave_bit(int cnt);
        logic [31:0] w;
        w = slv_pat(cnt / cfg_len);
        return w[cfg_len - 1 - (cnt % cfg_len)];
    endfunction

    function automatic logic [NCS-1:0] exp_cs(logic [1:0] sel, logic [NCS-1:0] pol, bit act);
        logic [NCS-1:0] v;
        for (int i = 0; i < NCS; i++) v[i] = (act && sel == 2'(i)) ? pol[i] : ~pol[i];
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // divider tick and transmit FIFO model
    always @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
        if (tx_pop) tx_rd <= tx_rd + 1;
    end
    assign tx_valid = (tx_rd < tx_avail);
    assign tx_data  = tx_mem[tx_rd[3:0]];

    // slave model and monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
        if (mon_en) begin
            if (spi_sclk != prev_sclk) begin
                edges++;
                if ((spi_sclk != clk_idle_high) == sample_first) begin
                    if (slv_cnt / cfg_len < 16)
                        cap[slv_cnt / cfg_len] = {cap[slv_cnt / cfg_len][30:0], spi_mosi};
                    slv_cnt++;
                    miso_r = slave_bit(slv_cnt);
                end
            end
            if (rx_push && rx_n < 16) begin rx_log[rx_n] = rx_data; rx_n++; end
            if (clk_underrun) ur_n++;
            if (clk_overrun) or_n++;
            if (done) done_n++;
        end
        prev_sclk = spi_sclk;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic arm(int fld, bit sf, bit idle, bit lb, bit full, int avail);
        step();
        word_len_m1 = 5'(fld);
        cfg_len = (fld < 3) ? 4 : fld + 1;
        sample_first = sf; clk_idle_high = idle; loopback = lb; rx_full = full;
        for (int i = 0; i < 16; i++) begin tx_mem[i] = tx_pat(i, fld); cap[i] = '0; rx_log[i] = '0; end
        tx_rd = 0; tx_avail = avail;
        rx_n = 0; ur_n = 0; or_n = 0; done_n = 0; edges = 0; slv_cnt = 0;
        miso_r = slave_bit(0);
        step(); step();
        mon_en = 1'b1;
        @(negedge clk);
        chk(spi_sclk == idle, "R5", "idle sclk level", 32'(spi_sclk), 32'(idle));
    endtask

    task automatic launch(int n);
        step(); go = 1'b1; go_words = CW'(n);
        step(); go = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R14", "busy after go", 32'(busy), 32'd1);
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (done_n == 0 && k < 20000) begin @(negedge clk); k++; end
        @(negedge clk);
        mon_en = 1'b0;
        chk(done_n == 1, "R14", "done pulses", 32'(done_n), 32'd1);
        chk(busy == 1'b0, "R14", "busy after done", 32'(busy), 32'd0);
    endtask

    task automatic check_data(string req, int n, bit lb, bit full);
        chk(edges == 2 * cfg_len * n, "R7", "sclk edge count", 32'(edges), 32'(2 * cfg_len * n));
        for (int i = 0; i < n; i++)
            chk(cap[i] == (tx_pat(i, 32'(word_len_m1)) & msk(cfg_len)), "R2", "mosi word",
                cap[i], tx_pat(i, 32'(word_len_m1)) & msk(cfg_len));
        if (full) begin
            chk(rx_n == 0, "R12", "pushes while full", 32'(rx_n), 32'd0);
            chk(or_n == n, "R12", "overrun pulses", 32'(or_n), 32'(n));
        end else begin
            chk(rx_n == n, "R3", "push count", 32'(rx_n), 32'(n));
            for (int i = 0; i < n; i++) begin
                logic [31:0] e;
                e = lb ? (tx_pat(i, 32'(word_len_m1)) & msk(cfg_len)) : (slv_pat(i) & msk(cfg_len));
                chk(rx_log[i] == e, req, "rx word", rx_log[i], e);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(spi_cs == 4'hF, "R1", "cs lines", 32'(spi_cs), 32'hF);
        chk(spi_sclk == 1'b0, "R1", "sclk", 32'(spi_sclk), 32'd0);
        chk({busy, done, tx_pop, rx_push} == 4'b0, "R1", "busy/done/pop/push",
            32'({busy, done, tx_pop, rx_push}), 32'd0);
    endtask

    task automatic t_xfer(string req, int fld, int n, bit sf, bit idle, bit lb);
        arm(fld, sf, idle, lb, 1'b0, n);
        launch(n);
        wait_done();
        check_data(req, n, lb, 1'b0);
    endtask

    task automatic t_zero_go();
        step(); go = 1'b1; go_words = '0;
        step(); go = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R14", "go with zero count", 32'(busy), 32'd0);
    endtask

    task automatic t_underrun();
        int e0;
        arm(7, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        launch(3);
        for (int k = 0; k < 2000 && ur_n == 0; k++) @(negedge clk);
        e0 = edges;
        for (int k = 0; k < 40; k++) @(negedge clk);
        chk(edges == e0, "R11", "sclk stalled", 32'(edges), 32'(e0));
        chk(spi_sclk == 1'b0, "R11", "stall sclk idle", 32'(spi_sclk), 32'd0);
        chk(ur_n == 1, "R11", "underrun pulse count", 32'(ur_n), 32'd1);
        step(); tx_avail = 3;
        wait_done();
        chk(ur_n == 1, "R11", "underrun after resume", 32'(ur_n), 32'd1);
        check_data("R11", 3, 1'b0, 1'b0);
    endtask

    task automatic t_overrun();
        arm(3, 1'b0, 1'b0, 1'b0, 1'b1, 5);
        launch(5);
        wait_done();
        check_data("R12", 5, 1'b0, 1'b1);
        step(); rx_full = 1'b0;
    endtask

    task automatic t_cs();
        step(); cs_sel = 2'd2; cs_pol = 4'b0101; cs_force = 1'b1; cs_auto = 1'b0;
        @(negedge clk);
        chk(spi_cs == exp_cs(2'd2, 4'b0101, 1'b1), "R8", "forced sel2", 32'(spi_cs), 32'(exp_cs(2'd2, 4'b0101, 1'b1)));
        step(); cs_sel = 2'd0; cs_pol = 4'b0000;
        @(negedge clk);
        chk(spi_cs == 4'b1110, "R9", "forced sel0 low", 32'(spi_cs), 32'hE);
        step(); cs_sel = 2'd1; cs_pol = 4'b0010; cs_force = 1'b0; cs_auto = 1'b1;
        @(negedge clk);
        chk(spi_cs == 4'b1101, "R9", "auto idle inactive", 32'(spi_cs), 32'hD);
        arm(7, 1'b1, 1'b0, 1'b0, 1'b0, 1);
        launch(1);
        chk(spi_cs == 4'b1111, "R9", "auto active in transfer", 32'(spi_cs), 32'hF);
        chk(pin_oe == 1'b1, "R10", "pin_oe while busy", 32'(pin_oe), 32'd1);
        wait_done();
        chk(spi_cs == 4'b1101, "R9", "auto after done", 32'(spi_cs), 32'hD);
        step(); cs_auto = 1'b0;
        arm(7, 1'b1, 1'b0, 1'b0, 1'b0, 1);
        launch(1);
        chk(spi_cs == 4'b1101, "R9", "no force/auto stays inactive", 32'(spi_cs), 32'hD);
        wait_done();
    endtask

    task automatic t_tristate();
        step(); cs_tristate = 1'b1; no_tristate = 1'b0;
        @(negedge clk);
        chk(cs_oe == 1'b0, "R10", "cs_oe floated", 32'(cs_oe), 32'd0);
        chk(pin_oe == 1'b0, "R10", "pin_oe idle", 32'(pin_oe), 32'd0);
        step(); cs_tristate = 1'b0; no_tristate = 1'b1;
        @(negedge clk);
        chk(cs_oe == 1'b1, "R10", "cs_oe driven", 32'(cs_oe), 32'd1);
        chk(pin_oe == 1'b1, "R10", "pin_oe no_tristate", 32'(pin_oe), 32'd1);
        step(); no_tristate = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin tx_mem[i] = '0; cap[i] = '0; rx_log[i] = '0; end
        repeat (4) @(posedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        t_xfer("R3", 7, 3, 1'b1, 1'b0, 1'b0);   // R4 sample-first mode
        t_xfer("R4", 31, 2, 1'b0, 1'b1, 1'b0);  // R5 idle-high, drive-first
        t_xfer("R6", 12, 4, 1'b1, 1'b1, 1'b1);  // loopback ignores miso
        t_xfer("R13", 1, 2, 1'b0, 1'b0, 1'b0);  // clamped to 4 bits
        t_zero_go();
        t_underrun();
        t_overrun();
        t_cs();
        t_tristate();
        summary();
        $finish;
    end
endmodule